// File: doc/BRIEF.md
# Core Tick Timer with Periodic Interrupt

This block is a free-running timer that runs on the bus clock. A divide-by-16 prescaler steps an 8-bit counter, so the counter wraps from 0xFF to 0x00 once every 4096 clocks. Each wrap sets a sticky overflow flag. Each wrap also steps a three-stage binary divider. A two-bit rate field picks how many wraps make up one periodic-interrupt interval: 1, 2, 4 or 8. When an interval completes, a second sticky flag is set.

Software reaches the block through one byte-wide register at a single address. The register holds both flags, an enable for each flag and the rate field. The flags cannot be written directly. Each flag has its own write-one-to-clear bit in the same byte. The single interrupt output is high while either flag is set and its enable is on.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the register reads 0x03 (rate field = 3, both flags and both enables = 0), and `irq` is low.
- R2: The register responds only at address 0x08. A write to any other address changes nothing. `rd_data` is registered: it shows the register value one clock after a cycle with `rd_en` high and a matching address, and it shows 0 after any other cycle.
- R3: The byte layout is bit 7 = overflow flag, bit 6 = periodic flag, bit 5 = overflow clear, bit 4 = periodic clear, bit 3 = overflow enable, bit 2 = periodic enable, bits 1:0 = rate. Bits 5 and 4 always read 0. A write loads bits 3:0 directly into the enables and the rate.
- R4: The counter wraps on clock edge 4096 after reset is released, and every 4096 edges after that. The overflow flag is set one edge after each wrap.
- R5: Writing 1 to bit 5 clears the overflow flag. Writing bit 7 has no effect.
- R6: With rate value r, the periodic flag is set once every 4096·2^r clocks, so rate 0, 1 and 3 give 4096, 8192 and 32768. Changing the rate does not restart the divider.
- R7: Writing 1 to bit 4 clears the periodic flag. Writing bit 6 has no effect.
- R8: `irq` is registered. It is high exactly one clock after (overflow flag AND overflow enable) OR (periodic flag AND periodic enable) holds.
- R9: If a flag's set event and its clear write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
The hardest case to reach from the ports is the collision in R9, where a clear write falls on the very edge at which the overflow flag is being set. The flag is only set once in 4096 clocks, so a hit at a random time is very unlikely. The bench therefore counts clock edges from the release of reset and places a clear write on edge 4097, the edge that turns the wrap pulse into the flag. It then checks that the flag still reads 1. The periodic rates are measured as the exact number of edges between two successive flag sets, with a clear write between them, so any error in the period shows as a cycle-count mismatch.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int DATA_W   = 8;
  // byte layout of the control/status register (software decodes it)
  localparam int B_OVF_F  = 7;
  localparam int B_PER_F  = 6;
  localparam int B_OVF_C  = 5;
  localparam int B_PER_C  = 4;
  localparam int B_OVF_E  = 3;
  localparam int B_PER_E  = 2;
endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (rst) pcnt <= '0;
        else if (pcnt == PW'(DIV - 1)) pcnt <= '0;
        else pcnt <= pcnt + 1'b1;
      end
      assign tick = (pcnt == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ctmr_count.sv
module ctmr_count #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic wrap
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= tick && (&cnt);
      if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctmr_rate_div.sv
module ctmr_rate_div #(
  parameter int STAGES = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SEL_W-1:0] rate,
  output logic             period_done
);
  logic [STAGES-1:0] stage;
  logic [STAGES:0]   tap_hit;
  logic              hit;

  assign tap_hit[0] = 1'b1;
  generate
    for (genvar i = 1; i <= STAGES; i++) begin : g_tap
      assign tap_hit[i] = &stage[i-1:0];
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k <= STAGES; k++)
      if (int'(rate) == k) hit = tap_hit[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage       <= '0;
      period_done <= 1'b0;
    end else begin
      period_done <= step && hit;
      if (step) stage <= stage + 1'b1;
    end
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h08,
  parameter int PRE_DIV    = 16,
  parameter int CNT_W      = 8,
  parameter int RTI_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq
);
  import ctmr_pkg::*;

  localparam int SEL_W = $clog2(RTI_STAGES + 1);

  logic             tick, ovf_pulse, per_pulse;
  logic             ovf_flag, per_flag, ovf_en, per_en;
  logic [SEL_W-1:0] rate;
  logic             sel, wr_hit, rd_hit, clr_ovf, clr_per;
  logic [7:0]       rd_word;

  ctmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ctmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wrap(ovf_pulse)
  );

  ctmr_rate_div #(.STAGES(RTI_STAGES), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .step(ovf_pulse), .rate(rate),
    .period_done(per_pulse)
  );

  assign sel     = (addr == REG_ADDR);
  assign wr_hit  = wr_en && sel;
  assign rd_hit  = rd_en && sel;
  assign clr_ovf = wr_hit && wr_data[B_OVF_C];
  assign clr_per = wr_hit && wr_data[B_PER_C];

  always_comb begin
    rd_word              = '0;
    rd_word[B_OVF_F]     = ovf_flag;
    rd_word[B_PER_F]     = per_flag;
    rd_word[B_OVF_E]     = ovf_en;
    rd_word[B_PER_E]     = per_en;
    rd_word[SEL_W-1:0]   = rate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      per_flag <= 1'b0;
      ovf_en   <= 1'b0;
      per_en   <= 1'b0;
      rate     <= '1;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else begin
      // set events take priority over a clear in the same cycle
      if (ovf_pulse)    ovf_flag <= 1'b1;
      else if (clr_ovf) ovf_flag <= 1'b0;
      if (per_pulse)    per_flag <= 1'b1;
      else if (clr_per) per_flag <= 1'b0;
      if (wr_hit) begin
        ovf_en <= wr_data[B_OVF_E];
        per_en <= wr_data[B_PER_E];
        rate   <= wr_data[SEL_W-1:0];
      end
      irq     <= (ovf_flag && ovf_en) || (per_flag && per_en);
      rd_data <= rd_hit ? rd_word : 8'h00;
    end
  end
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker (
  input logic       clk,
  input logic       rst,
  input logic       ovf_pulse,
  input logic       per_pulse,
  input logic       clr_ovf,
  input logic       clr_per,
  input logic       ovf_flag,
  input logic       per_flag,
  input logic       ovf_en,
  input logic       per_en,
  input logic       irq,
  input logic [7:0] rd_data
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && rd_data == 8'h00));
  a_r3_clear_bits_read_zero: assert property (@(posedge clk) disable iff (rst) rd_data[5:4] == 2'b00);
  a_r4_ovf_needs_wrap: assert property (@(posedge clk) disable iff (rst) $rose(ovf_flag) |-> $past(ovf_pulse));
  a_r5_ovf_clear: assert property (@(posedge clk) disable iff (rst) (clr_ovf && !ovf_pulse) |=> !ovf_flag);
  a_r6_per_needs_period: assert property (@(posedge clk) disable iff (rst) $rose(per_flag) |-> $past(per_pulse));
  a_r7_per_clear: assert property (@(posedge clk) disable iff (rst) (clr_per && !per_pulse) |=> !per_flag);
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst) ((ovf_flag && ovf_en) || (per_flag && per_en)) |=> irq);
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && irq) |-> $past((ovf_flag && ovf_en) || (per_flag && per_en)));
  a_r9_set_wins_ovf: assert property (@(posedge clk) disable iff (rst) (ovf_pulse && clr_ovf) |=> ovf_flag);
  a_r9_set_wins_per: assert property (@(posedge clk) disable iff (rst) (per_pulse && clr_per) |=> per_flag);
endmodule

bind core_tick_timer ctmr_checker u_ctmr_checker (
  .clk(clk), .rst(rst), .ovf_pulse(ovf_pulse), .per_pulse(per_pulse),
  .clr_ovf(clr_ovf), .clr_per(clr_per), .ovf_flag(ovf_flag),
  .per_flag(per_flag), .ovf_en(ovf_en), .per_en(per_en),
  .irq(irq), .rd_data(rd_data)
);

// File: tb/test_core_tick_timer.sv
`timescale 1ns/1ps
module test_core_tick_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h08;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b1;
  logic [7:0] rd_data;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  core_tick_timer i_core_tick_timer (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // every task leaves the bench just after a falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b1; addr = 8'h08;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic write_reg(logic [7:0] a, logic [7:0] d);
    addr = a; wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; addr = 8'h08;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq after reset", irq, 0);
    step();
    check("R1 reset value", rd_data, 8'h03);
  endtask

  task automatic t_layout();
    do_reset();
    write_reg(8'h08, 8'hFF);
    step();
    check("R3/R5/R7 flag bits not writable, clear bits read 0", rd_data, 8'h0F);
    check("R8 no irq without flags", irq, 0);
    write_reg(8'h08, 8'h05);
    step();
    check("R3 low nibble loads", rd_data, 8'h05);
  endtask

  task automatic t_addr();
    do_reset();
    write_reg(8'h08, 8'h05);
    write_reg(8'h09, 8'h0A);
    step();
    check("R2 foreign write ignored", rd_data, 8'h05);
    addr = 8'h09;
    step();
    check("R2 foreign read gives 0", rd_data, 8'h00);
    addr = 8'h08; rd_en = 1'b0;
    step();
    check("R2 no read strobe gives 0", rd_data, 8'h00);
    rd_en = 1'b1;
    step();
  endtask

  task automatic t_overflow();
    do_reset();
    repeat (4090) step();
    check("R4 no overflow before wrap", rd_data[7], 0);
    repeat (10) step();
    check("R4 overflow flag after wrap", rd_data, 8'h83);
    check("R8 irq masked", irq, 0);
    write_reg(8'h08, 8'h8B);
    step();
    check("R8 irq with enable", irq, 1);
    check("R5 bit7 write no effect", rd_data, 8'h8B);
    write_reg(8'h08, 8'h2B);
    step();
    check("R5 clear by bit5", rd_data, 8'h0B);
    check("R8 irq drops after clear", irq, 0);
  endtask

  task automatic t_collision();
    do_reset();
    repeat (4096) step();
    write_reg(8'h08, 8'h23);   // clear lands on the flag-set edge 4097
    step();
    check("R9 set wins over clear", rd_data, 8'h83);
    write_reg(8'h08, 8'h23);
    step();
    check("R5 later clear works", rd_data, 8'h03);
  endtask

  task automatic t_rate(logic [1:0] r);
    int n = 0;
    do_reset();
    write_reg(8'h08, {6'b000001, r});
    while (!rd_data[6] && n < 70000) begin step(); n++; end
    check("R8 irq from periodic flag", irq, 1);
    write_reg(8'h08, {6'b000101, r});
    n = 1;
    while (rd_data[6] && n < 70000) begin step(); n++; end
    while (!rd_data[6] && n < 70000) begin step(); n++; end
    check($sformatf("R6 period rate %0d", r), n, 32'd4096 << r);
    check("R7 bit6 write no effect, flag set", rd_data[6], 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_layout();
    t_addr();
    t_overflow();
    t_collision();
    t_rate(2'd0);
    t_rate(2'd1);
    t_rate(2'd3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule